// File: doc/BRIEF.md
# Dual-Width Operand Stack

This block is the operand store of an arithmetic coprocessor. One bank of eight 16-bit registers serves as either an 8-deep stack of 16-bit integers or a 4-deep stack of 32-bit values, where each 32-bit value takes two adjacent 16-bit slots. The arithmetic datapath reads the top two entries, performs its work elsewhere, and returns one result word. The stack then either replaces the top of stack (TOS) with that word (unary operations) or writes it over the next-on-stack (NOS) and moves up (binary operations). The stack can also duplicate its top entry at either width, or push the single-precision encoding of pi.

Commands arrive one at a time on a valid-qualified command port. A three-state controller named `S_IDLE`, `S_EXEC` and `S_DONE` handles them. The transition `S_IDLE -> S_EXEC` takes the command when `cmd_valid` is high. `S_EXEC -> S_DONE` is unconditional and writes the register bank and the flags. `S_DONE -> S_IDLE` is also unconditional, and `done` pulses during `S_DONE`. Without `cmd_valid` the controller stays in `S_IDLE`. After every command the sign and zero of the new TOS are registered, at the width of that command.

Top module: `opstk_top`

## Requirements
- R1: Reset sets all eight 16-bit entries to zero. It also drives `tos_o`=0, `nos_o`=0, `sign_o`=0, `zero_o`=1, `busy`=0 and `done`=0.
- R2: A 16-bit duplicate (`cmd_op`=00, `cmd_wide`=0) shifts every 16-bit entry down one slot and keeps the old TOS in slot 0. The old slot 7 is discarded.
- R3: A 32-bit duplicate (`cmd_op`=00, `cmd_wide`=1) shifts every 32-bit entry down one position and keeps the old 32-bit TOS. The old bottom 32-bit entry is discarded.
- R4: A constant push (`cmd_op`=01) always works at 32-bit width, whatever `cmd_wide` is. It shifts the 32-bit stack down so that the old TOS becomes the NOS, and loads 32'h40490FDB into the TOS.
- R5: A 16-bit binary writeback (`cmd_op`=10, `cmd_wide`=0) puts `cmd_data[15:0]` in slot 0 and moves slots 2..7 up into slots 1..6.
- R6: A 32-bit binary writeback (`cmd_op`=10, `cmd_wide`=1) puts `cmd_data` in the 32-bit TOS and moves 32-bit entries 2..3 up into positions 1..2.
- R7: A unary replace (`cmd_op`=11) writes `cmd_data[15:0]` into slot 0 (16-bit) or `cmd_data` into the 32-bit TOS (wide). No other entry changes.
- R8: A command is taken only in `S_IDLE`. `busy` is high for the two cycles after it is taken. `done` is high only in the second of those cycles, when the new stack contents are already visible. `cmd_valid` has no effect while `busy` is high.
- R9: `sign_o` is the most significant bit of the new TOS at the command's width. `zero_o` is high when that TOS is all zeros. Both flags change only at command completion.
- R10: 32-bit entry k is {slot 2k+1, slot 2k}. `tos_o` is 32-bit entry 0 and `nos_o` is 32-bit entry 1, so the 16-bit TOS and NOS appear as `tos_o[15:0]` and `tos_o[31:16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Operation: 00 dup, 01 const, 10 binary writeback, 11 unary replace |
| cmd_wide | input | 1 | 1 selects the 32-bit view |
| cmd_data | input | 32 | Result word from the datapath |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| tos_o | output | 32 | 32-bit entry 0 (slots 1:0) |
| nos_o | output | 32 | 32-bit entry 1 (slots 3:2) |
| sign_o | output | 1 | Sign of new TOS |
| zero_o | output | 1 | New TOS is zero |

## Verification
Every operation code is crossed with both widths and with result words of zero, a sign bit in only one half, all ones and mixed bits. This separates the 16-bit and 32-bit sign and zero paths and shows whether each half lands in the right slot. A long pseudo-random command sequence then drives the stack through deep fill and drain. Pops bring lower entries up into the TOS and NOS, where an ordering or shift-distance error becomes visible. Commands driven during `busy` carry the inverted operation and data, so a command that should have been ignored but was taken changes the expected contents.

// File: rtl/opstk_pkg.sv
package opstk_pkg;
    localparam int WORD_W = 16;
    localparam int WIDE_W = 2 * WORD_W;
    localparam logic [WIDE_W-1:0] PI_F32 = 32'h40490FDB;

    typedef enum logic [1:0] {
        OP_DUP   = 2'b00,
        OP_CONST = 2'b01,
        OP_BINWB = 2'b10,
        OP_UNARY = 2'b11
    } stk_op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EXEC = 2'd1,
        S_DONE = 2'd2
    } ctl_state_e;

    typedef struct packed {
        stk_op_e           op;
        logic              wide;
        logic [WIDE_W-1:0] data;
    } stk_cmd_t;
endpackage

// File: rtl/opstk_fsm.sv
module opstk_fsm
    import opstk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_valid,
    input  stk_cmd_t cmd_in,
    output stk_cmd_t cmd_q,
    output logic     wr_en,
    output logic     busy,
    output logic     done
);
    ctl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (cmd_valid) state_d = S_EXEC;
            S_EXEC:  state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                             cmd_q <= '0;
        else if (state_q == S_IDLE && cmd_valid) cmd_q <= cmd_in;
    end

    always_comb begin
        wr_en = 1'b0;
        busy  = 1'b1;
        done  = 1'b0;
        unique case (state_q)
            S_IDLE:  busy  = 1'b0;
            S_EXEC:  wr_en = 1'b1;
            S_DONE:  done  = 1'b1;
            default: busy  = 1'b0;
        endcase
    end

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid) |=> (busy && !done));
    a_r8_exec_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> done);
    a_r8_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(cmd_q));
endmodule

// File: rtl/opstk_file.sv
module opstk_file
    import opstk_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  stk_cmd_t                     cmd,
    output logic [DEPTH-1:0][WORD_W-1:0] ent_o,
    output logic [WIDE_W-1:0]            tos_next_o,
    output logic                         wide_eff_o
);
    logic [WORD_W-1:0] ent_q [DEPTH];
    logic [WORD_W-1:0] ent_d [DEPTH];
    logic              wide_eff;

    assign wide_eff   = cmd.wide | (cmd.op == OP_CONST);
    assign wide_eff_o = wide_eff;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [WORD_W-1:0] dn1, dn2, up1, up2, lit, cst;
        if (i >= 1) begin : g_dn1
            assign dn1 = ent_q[i-1];
        end else begin : g_dn1k
            assign dn1 = ent_q[i];
        end
        if (i >= 2) begin : g_dn2
            assign dn2 = ent_q[i-2];
        end else begin : g_dn2k
            assign dn2 = ent_q[i];
        end
        if (i + 1 < DEPTH) begin : g_up1
            assign up1 = ent_q[i+1];
        end else begin : g_up1k
            assign up1 = ent_q[i];
        end
        if (i + 2 < DEPTH) begin : g_up2
            assign up2 = ent_q[i+2];
        end else begin : g_up2k
            assign up2 = ent_q[i];
        end
        assign lit = cmd.data[(i % 2) * WORD_W +: WORD_W];
        assign cst = PI_F32[(i % 2) * WORD_W +: WORD_W];

        always_comb begin
            ent_d[i] = ent_q[i];
            unique case (cmd.op)
                OP_DUP: begin
                    if (wide_eff) ent_d[i] = (i < 2) ? ent_q[i] : dn2;
                    else          ent_d[i] = (i < 1) ? ent_q[i] : dn1;
                end
                OP_CONST: ent_d[i] = (i < 2) ? cst : dn2;
                OP_BINWB: begin
                    if (wide_eff) ent_d[i] = (i < 2) ? lit : up2;
                    else          ent_d[i] = (i < 1) ? lit : up1;
                end
                OP_UNARY: begin
                    if (i == 0 || (i == 1 && wide_eff)) ent_d[i] = lit;
                end
                default: ent_d[i] = ent_q[i];
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n)     ent_q[i] <= '0;
            else if (wr_en) ent_q[i] <= ent_d[i];
        end

        assign ent_o[i] = ent_q[i];
    end

    assign tos_next_o = {ent_d[1], ent_d[0]};

    a_r2_dup16: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd.op == OP_DUP && !cmd.wide) |=>
        (ent_q[0] == $past(ent_q[0]) && ent_q[1] == $past(ent_q[0])
         && ent_q[DEPTH-1] == $past(ent_q[DEPTH-2])));
    a_r3_dup32: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd.op == OP_DUP && cmd.wide) |=>
        ({ent_q[3], ent_q[2]} == $past({ent_q[1], ent_q[0]})
         && ent_q[1] == $past(ent_q[1])));
    a_r4_const: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd.op == OP_CONST) |=>
        ({ent_q[1], ent_q[0]} == PI_F32
         && {ent_q[3], ent_q[2]} == $past({ent_q[1], ent_q[0]})));
    a_r5_binwb16: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd.op == OP_BINWB && !cmd.wide) |=>
        (ent_q[0] == $past(cmd.data[WORD_W-1:0]) && ent_q[1] == $past(ent_q[2])));
    a_r6_binwb32: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd.op == OP_BINWB && cmd.wide) |=>
        ({ent_q[1], ent_q[0]} == $past(cmd.data)
         && {ent_q[3], ent_q[2]} == $past({ent_q[5], ent_q[4]})));
    a_r7_unary: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd.op == OP_UNARY) |=>
        (ent_q[0] == $past(cmd.data[WORD_W-1:0]) && ent_q[2] == $past(ent_q[2])));
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(ent_q[0]) && $stable(ent_q[DEPTH-1])));
endmodule

// File: rtl/opstk_flags.sv
module opstk_flags
    import opstk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic              wide,
    input  logic [WIDE_W-1:0] tos_next,
    input  logic [WIDE_W-1:0] tos_now,
    output logic              sign_o,
    output logic              zero_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sign_o <= 1'b0;
            zero_o <= 1'b1;
        end else if (upd) begin
            sign_o <= wide ? tos_next[WIDE_W-1] : tos_next[WORD_W-1];
            zero_o <= wide ? (tos_next == '0) : (tos_next[WORD_W-1:0] == '0);
        end
    end

    a_r9_sign: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (sign_o == ($past(wide) ? tos_now[WIDE_W-1] : tos_now[WORD_W-1])));
    a_r9_zero: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (zero_o == ($past(wide) ? (tos_now == '0) : (tos_now[WORD_W-1:0] == '0))));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(sign_o) && $stable(zero_o)));
endmodule

// File: rtl/opstk_top.sv
module opstk_top
    import opstk_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic        cmd_wide,
    input  logic [31:0] cmd_data,
    output logic        busy,
    output logic        done,
    output logic [31:0] tos_o,
    output logic [31:0] nos_o,
    output logic        sign_o,
    output logic        zero_o
);
    stk_cmd_t                     cmd_in, cmd_q;
    logic                         wr_en, wide_eff;
    logic [DEPTH-1:0][WORD_W-1:0] ent;
    logic [WIDE_W-1:0]            tos_next;

    assign cmd_in.op   = stk_op_e'(cmd_op);
    assign cmd_in.wide = cmd_wide;
    assign cmd_in.data = cmd_data;

    opstk_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_in(cmd_in),
        .cmd_q(cmd_q), .wr_en(wr_en), .busy(busy), .done(done)
    );

    opstk_file #(.DEPTH(DEPTH)) u_file (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd(cmd_q),
        .ent_o(ent), .tos_next_o(tos_next), .wide_eff_o(wide_eff)
    );

    assign tos_o = {ent[1], ent[0]};
    assign nos_o = {ent[3], ent[2]};

    opstk_flags u_flags (
        .clk(clk), .rst_n(rst_n), .upd(wr_en), .wide(wide_eff),
        .tos_next(tos_next), .tos_now(tos_o), .sign_o(sign_o), .zero_o(zero_o)
    );

    a_r8_done_sees_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
endmodule

// File: tb/opstk_top_tb_top.sv
module opstk_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic        cmd_wide = 1'b0;
    logic [31:0] cmd_data = '0;
    logic        busy, done, sign_o, zero_o;
    logic [31:0] tos_o, nos_o;

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] m [8];
    bit          kn [8];
    logic [31:0] lfsr = 32'hACE1_2357;

    localparam logic [31:0] PI_F = 32'h40490FDB;

    always #5 clk = ~clk;

    opstk_top dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wide(cmd_wide), .cmd_data(cmd_data), .busy(busy), .done(done),
        .tos_o(tos_o), .nos_o(nos_o), .sign_o(sign_o), .zero_o(zero_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string op_req(input int op, input bit wide);
        case (op)
            0:       return wide ? "R3 dup32" : "R2 dup16";
            1:       return "R4 const";
            2:       return wide ? "R6 binwb32" : "R5 binwb16";
            default: return "R7 unary";
        endcase
    endfunction

    function automatic void model_apply(input int op, input bit wide, input logic [31:0] d);
        int s;
        bit we;
        we = wide || (op == 1);
        s  = we ? 2 : 1;
        case (op)
            0, 1: begin
                for (int i = 7; i >= s; i--) begin
                    m[i] = m[i-s];
                    kn[i] = kn[i-s];
                end
                if (op == 1) begin
                    m[0] = PI_F[15:0]; m[1] = PI_F[31:16];
                    kn[0] = 1; kn[1] = 1;
                end
            end
            2: begin
                for (int i = 0; i < 8; i++) begin
                    if (i < s) begin
                        m[i] = d[(i%2)*16 +: 16]; kn[i] = 1;
                    end else if (i + s <= 7) begin
                        m[i] = m[i+s]; kn[i] = kn[i+s];
                    end else begin
                        kn[i] = 0;
                    end
                end
            end
            default: begin
                m[0] = d[15:0]; kn[0] = 1;
                if (we) begin m[1] = d[31:16]; kn[1] = 1; end
            end
        endcase
    endfunction

    // R10: slots 1:0 on tos_o, slots 3:2 on nos_o
    task automatic check_view(input string req);
        if (kn[0]) chk({req, " R10 slot0"}, {16'h0, tos_o[15:0]},  {16'h0, m[0]});
        if (kn[1]) chk({req, " R10 slot1"}, {16'h0, tos_o[31:16]}, {16'h0, m[1]});
        if (kn[2]) chk({req, " R10 slot2"}, {16'h0, nos_o[15:0]},  {16'h0, m[2]});
        if (kn[3]) chk({req, " R10 slot3"}, {16'h0, nos_o[31:16]}, {16'h0, m[3]});
    endtask

    task automatic check_flags(input bit we);
        if (we && kn[0] && kn[1]) begin
            chk("R9 sign32", {31'h0, sign_o}, {31'h0, m[1][15]});
            chk("R9 zero32", {31'h0, zero_o}, {31'h0, ({m[1], m[0]} == 32'h0)});
        end else if (!we && kn[0]) begin
            chk("R9 sign16", {31'h0, sign_o}, {31'h0, m[0][15]});
            chk("R9 zero16", {31'h0, zero_o}, {31'h0, (m[0] == 16'h0)});
        end
    endtask

    task automatic issue(input int op, input bit wide, input logic [31:0] d, input bit inject);
        string req;
        req = op_req(op, wide);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_wide = wide; cmd_data = d;
        @(negedge clk);
        chk("R8 busy after accept", {31'h0, busy}, 32'h1);
        chk("R8 no early done", {31'h0, done}, 32'h0);
        if (inject) begin
            cmd_op = ~cmd_op; cmd_wide = ~wide; cmd_data = ~d;
        end else begin
            cmd_valid = 1'b0;
        end
        model_apply(op, wide, d);
        @(negedge clk);
        chk("R8 done pulse", {31'h0, done}, 32'h1);
        check_view(req);
        check_flags(wide || op == 1);
        cmd_valid = 1'b0;
        @(negedge clk);
        chk("R8 done ends", {30'h0, busy, done}, 32'h0);
    endtask

    function automatic logic [31:0] step(input logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] pats [6];
        pats[0] = 32'h0000_0000; pats[1] = 32'h8000_0000; pats[2] = 32'h0000_8000;
        pats[3] = 32'hFFFF_FFFF; pats[4] = 32'h1234_5678; pats[5] = 32'h0001_0000;
        for (int i = 0; i < 8; i++) begin m[i] = 16'h0; kn[i] = 1; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tos", tos_o, 32'h0);
        chk("R1 nos", nos_o, 32'h0);
        chk("R1 flags", {30'h0, sign_o, zero_o}, 32'h1);
        chk("R1 handshake", {30'h0, busy, done}, 32'h0);

        // Sweep: every op x width x pattern
        for (int op = 0; op < 4; op++)
            for (int w = 0; w < 2; w++)
                for (int p = 0; p < 6; p++)
                    issue(op, w[0], pats[p], (p % 2) == 1);

        // Fill with distinct words, then drain to surface deep slots
        for (int i = 0; i < 8; i++) begin
            issue(0, 1'b0, 32'h0, 1'b0);
            issue(3, 1'b0, 32'h0000_A100 + 32'(i), 1'b0);
        end
        for (int i = 0; i < 7; i++) issue(2, 1'b0, 32'h0000_B200 + 32'(i), i == 3);
        issue(1, 1'b0, 32'h0, 1'b0);
        issue(0, 1'b1, 32'h0, 1'b1);
        for (int i = 0; i < 3; i++) issue(2, 1'b1, 32'hC300_0000 + 32'(i), 1'b0);

        // Pseudo-random command stream
        for (int n = 0; n < 700; n++) begin
            lfsr = step(lfsr);
            issue(int'(lfsr[3:2]), lfsr[5], (lfsr[7:6] == 2'b00) ? 32'h0 : step(lfsr), lfsr[9:8] == 2'b11);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule